// File: doc/BRIEF.md
# Bus-Attached Down-Counting Interval Timer

A single-channel memory-mapped timer on an APB slave port. A counter of `CNT_W` bits (32 by default) decrements once per bus clock while enabled and raises an interrupt each time it runs out. When it runs out it reloads. In periodic mode it reloads the programmed load value. In free-running mode it reloads all ones.

Software programs the load value while the timer is stopped. It starts the timer by setting the enable bit, which copies the load value into the counter. Software can also sample the live count at any time, for example to build an up-counting time base by inverting it. The interrupt has a latched raw flag and a mask bit. The flag is cleared by reading one of two end-of-interrupt addresses.

The slave answers every access with no wait states. A fixed identification word is readable at its own offset.

Top module: `apb_interval_timer`

## Requirements
- R1: After a synchronous reset, the load value, the control fields, the counter and the raw interrupt flag are all zero. `irq` is low.
- R2: The register word offsets are as follows. Load is at 0x00 and reads back its low `CNT_W` bits. Current count is at 0x04. Control is at 0x08. Channel EOI is at 0x0C. Channel status is at 0x10, with the masked flag in bit 0. Global masked status is at 0xA0, bit 0. Global EOI is at 0xA4. Global raw status is at 0xA8, bit 0. The identification word is at 0xAC and returns the `VERSION` parameter. Every other offset reads zero.
- R3: The control word has three fields: bit 0 is enable, bit 1 is periodic, bit 2 is mask. It reads back with zeros above bit 2. On a write that takes enable from 0 to 1, the counter holds the load value N in the next cycle and then decrements by one per cycle. The raw flag, and an unmasked `irq`, go high N+2 clock edges after the enabling write's access edge.
- R4: In periodic mode, an expiry reloads the counter with the load value. A read in the access cycle that follows the first cycle with `irq` high returns N-1, or 0 when N is 0.
- R5: In free-running mode, an expiry reloads the counter with all ones. The same read returns all ones minus one.
- R6: While enable is 0, the counter keeps its value and no expiry occurs. The counter still decrements on the edge that clears enable.
- R7: An expiry sets the raw flag whatever the mask bit is. `irq` and both masked status bits equal the raw flag AND NOT mask.
- R8: A read of 0x0C or 0xA4 clears the raw flag. If an expiry occurs in the same cycle, the flag stays set.
- R9: Reads of the count and status registers have no side effects. `pready` is always high. Writes take effect only in the access phase. Writes to read-only or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and count clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high (no wait states) |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the timer with `CNT_W` = 8 and a non-default `VERSION` word. With an 8-bit counter, the all-ones reload of free-running mode and a full sweep of load values are reachable within a few hundred cycles. The bench sweeps load values 0 to 12 in periodic mode and 0 to 5 in free-running mode. For each one it checks the exact expiry latency and the reload value. Directed sequences then cover the mask, both EOI paths, an EOI that coincides with an expiry, holding while stopped, and ignored writes.

// File: rtl/apb_tmr_pkg.sv
package apb_tmr_pkg;

  // word offsets (byte offset >> 2); software depends on these
  localparam logic [5:0] WO_LOAD  = 6'h00;
  localparam logic [5:0] WO_CUR   = 6'h01;
  localparam logic [5:0] WO_CTL   = 6'h02;
  localparam logic [5:0] WO_EOI   = 6'h03;
  localparam logic [5:0] WO_STAT  = 6'h04;
  localparam logic [5:0] WO_GMSK  = 6'h28;
  localparam logic [5:0] WO_GEOI  = 6'h29;
  localparam logic [5:0] WO_GRAW  = 6'h2A;
  localparam logic [5:0] WO_VER   = 6'h2B;

  localparam int unsigned BUS_W = 32;

  typedef struct packed {
    logic mask;      // bit 2
    logic periodic;  // bit 1
    logic enable;    // bit 0
  } tmr_ctl_t;

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import apb_tmr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              raw_flag,
  input  logic              msk_flag,
  output tmr_ctl_t          ctl,
  output logic [CNT_W-1:0]  load_val,
  output logic              eoi_hit,
  output logic [BUS_W-1:0]  prdata
);

  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic              wr_acc;
  logic              rd_acc;
  logic [BUS_W-1:0]  cnt_ext;
  logic [BUS_W-1:0]  load_ext;

  assign widx    = paddr[ADDR_W-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr_acc  = psel & penable &  pwrite & aligned;
  assign rd_acc  = psel & penable & ~pwrite & aligned;

  generate
    if (CNT_W < BUS_W) begin : g_narrow
      assign cnt_ext  = {{(BUS_W-CNT_W){1'b0}}, cnt};
      assign load_ext = {{(BUS_W-CNT_W){1'b0}}, load_val};
    end else begin : g_full
      assign cnt_ext  = cnt;
      assign load_ext = load_val;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      load_val <= '0;
    end else if (wr_acc) begin
      if (widx == WIDX_W'(WO_LOAD)) load_val <= pwdata[CNT_W-1:0];
      if (widx == WIDX_W'(WO_CTL))  ctl      <= tmr_ctl_t'(pwdata[2:0]);
    end
  end

  assign eoi_hit = rd_acc & ((widx == WIDX_W'(WO_EOI)) | (widx == WIDX_W'(WO_GEOI)));

  always_comb begin
    prdata = '0;
    if (psel & ~pwrite & aligned) begin
      unique case (widx)
        WIDX_W'(WO_LOAD): prdata = load_ext;
        WIDX_W'(WO_CUR):  prdata = cnt_ext;
        WIDX_W'(WO_CTL):  prdata = {{(BUS_W-3){1'b0}}, ctl};
        WIDX_W'(WO_STAT): prdata = {{(BUS_W-1){1'b0}}, msk_flag};
        WIDX_W'(WO_GMSK): prdata = {{(BUS_W-1){1'b0}}, msk_flag};
        WIDX_W'(WO_GRAW): prdata = {{(BUS_W-1){1'b0}}, raw_flag};
        WIDX_W'(WO_VER):  prdata = VERSION;
        default:          prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import apb_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_ctl_t         ctl,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             en_rise,
  output logic             expire
);

  logic en_d;

  assign en_rise = ctl.enable & ~en_d;
  assign expire  = ctl.enable & en_d & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      en_d <= 1'b0;
    end else begin
      en_d <= ctl.enable;
      if (en_rise) begin
        cnt <= load_val;
      end else if (expire) begin
        cnt <= ctl.periodic ? load_val : '1;
      end else if (ctl.enable) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic eoi_hit,
  input  logic mask,
  output logic raw_flag,
  output logic msk_flag
);

  always_ff @(posedge clk) begin
    if (rst)          raw_flag <= 1'b0;
    else if (expire)  raw_flag <= 1'b1;
    else if (eoi_hit) raw_flag <= 1'b0;
  end

  assign msk_flag = raw_flag & ~mask;

endmodule

// File: rtl/apb_interval_timer.sv
module apb_interval_timer
  import apb_tmr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CNT_W   = 32,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              irq
);

  tmr_ctl_t         ctl;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             en_rise;
  logic             expire;
  logic             eoi_hit;
  logic             raw_flag;
  logic             msk_flag;

  assign pready = 1'b1;
  assign irq    = msk_flag;

  tmr_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .VERSION(VERSION)) u_regif (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .cnt(cnt), .raw_flag(raw_flag),
    .msk_flag(msk_flag), .ctl(ctl), .load_val(load_val), .eoi_hit(eoi_hit),
    .prdata(prdata)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .ctl(ctl), .load_val(load_val), .cnt(cnt),
    .en_rise(en_rise), .expire(expire)
  );

  tmr_irq u_irq (
    .clk(clk), .rst(rst), .expire(expire), .eoi_hit(eoi_hit),
    .mask(ctl.mask), .raw_flag(raw_flag), .msk_flag(msk_flag)
  );

endmodule

// File: rtl/apb_interval_timer_chk.sv
module apb_interval_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             pready,
  input logic             irq,
  input logic             en,
  input logic             periodic,
  input logic             mask,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val,
  input logic             en_rise,
  input logic             expire,
  input logic             eoi_hit,
  input logic             raw_flag
);

  p_ready_high_r9: assert property (@(posedge clk) disable iff (rst) pready);

  p_start_load_r3: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> cnt == $past(load_val));

  p_periodic_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (expire && periodic) |=> cnt == $past(load_val));

  p_free_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (expire && !periodic) |=> (&cnt));

  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));

  p_mask_gate_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!mask && raw_flag));

  p_expire_sets_r8: assert property (@(posedge clk) disable iff (rst)
    expire |=> raw_flag);

  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (eoi_hit && !expire) |=> !raw_flag);

endmodule

bind apb_interval_timer apb_interval_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .pready(pready), .irq(irq),
  .en(ctl.enable), .periodic(ctl.periodic), .mask(ctl.mask),
  .cnt(cnt), .load_val(load_val), .en_rise(en_rise), .expire(expire),
  .eoi_hit(eoi_hit), .raw_flag(raw_flag)
);

// File: tb/apb_interval_timer_tb.sv
`timescale 1ns/1ps
module apb_interval_timer_tb;

  localparam int unsigned CW  = 8;
  localparam logic [31:0] VER = 32'h1357_2468;
  localparam logic [31:0] ONES_M1 = (32'h1 << CW) - 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  apb_interval_timer #(.ADDR_W(8), .CNT_W(CW), .VERSION(VER)) u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // both tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1; #1;
    d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!irq && k < 2000) begin @(negedge clk); k++; end
  endtask

  initial begin
    #1_000_000;
    $display("FAIL watchdog: actual timeout expected finish");
    fails++;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int k;
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R1 load", v, 32'h0);
    rd(8'h04, v); chk("R1 count", v, 32'h0);
    rd(8'h08, v); chk("R1 ctl", v, 32'h0);
    rd(8'hA8, v); chk("R1 raw", v, 32'h0);
    // R2 map
    rd(8'hAC, v); chk("R2 version", v, VER);
    rd(8'h40, v); chk("R2 unmapped", v, 32'h0);
    wr(8'h00, 32'hABCD_EF12);
    rd(8'h00, v); chk("R2 load width", v, 32'h12);
    wr(8'h08, 32'h0000_00F4);
    rd(8'h08, v); chk("R3 ctl readback", v, 32'h4);
    wr(8'h08, 32'h0);

    // R3/R4 periodic sweep
    for (int n = 0; n <= 12; n++) begin
      wr(8'h08, 32'h0); wr(8'hA4, 32'h0); rd(8'hA4, v);
      wr(8'h00, n);
      wr(8'h08, 32'h3);
      wait_irq(k);
      chk($sformatf("R3 latency n=%0d", n), k, n + 2);
      rd(8'h04, v);
      chk($sformatf("R4 reload n=%0d", n), v, (n == 0) ? 0 : n - 1);
    end
    // R5 free-running sweep
    for (int n = 0; n <= 5; n++) begin
      wr(8'h08, 32'h0); rd(8'hA4, v);
      wr(8'h00, n);
      wr(8'h08, 32'h1);
      wait_irq(k);
      chk($sformatf("R5 latency n=%0d", n), k, n + 2);
      rd(8'h04, v);
      chk($sformatf("R5 reload n=%0d", n), v, ONES_M1);
    end

    // R8 channel EOI clears
    wr(8'h08, 32'h0); rd(8'hA4, v);
    wr(8'h00, 32'd30); wr(8'h08, 32'h3);
    wait_irq(k);
    rd(8'h0C, v);
    chk("R8 eoi read data", v, 32'h0);
    chk("R8 channel eoi clears", {31'b0, irq}, 32'h0);
    rd(8'hA8, v); chk("R8 raw cleared", v, 32'h0);

    // R6 hold while stopped, R3 restart from load
    wr(8'h08, 32'h0); rd(8'hA4, v);
    wr(8'h00, 32'd20); wr(8'h08, 32'h3);
    idle(3);
    wr(8'h08, 32'h2);
    rd(8'h04, v); chk("R6 stop value", v, 32'd16);
    idle(40);
    rd(8'h04, v2); chk("R6 held", v2, 32'd16);
    chk("R6 no irq", {31'b0, irq}, 32'h0);
    // R9 ignored writes to read-only and unmapped offsets
    wr(8'h04, 32'h55); wr(8'hAC, 32'h0); wr(8'hA8, 32'h1); wr(8'h40, 32'h7);
    rd(8'h04, v); chk("R9 count write ignored", v, 32'd16);
    rd(8'hAC, v); chk("R9 version write ignored", v, VER);
    rd(8'hA8, v); chk("R9 raw write ignored", v, 32'h0);
    rd(8'h40, v); chk("R9 unmapped stays zero", v, 32'h0);
    rd(8'h08, v); chk("R9 ctl untouched", v, 32'h2);
    wr(8'h08, 32'h3);
    rd(8'h04, v); chk("R3 restart loads", v, 32'd20);

    // R7 mask
    wr(8'h08, 32'h0); rd(8'hA4, v);
    wr(8'h00, 32'd2); wr(8'h08, 32'h7);
    idle(10);
    chk("R7 masked irq low", {31'b0, irq}, 32'h0);
    rd(8'hA8, v); chk("R7 raw set", v, 32'h1);
    rd(8'hA0, v); chk("R7 global masked", v, 32'h0);
    rd(8'h10, v); chk("R7 channel masked", v, 32'h0);
    // R9 status reads have no side effect
    rd(8'hA8, v); chk("R9 raw after reads", v, 32'h1);
    wr(8'h08, 32'h3);
    chk("R7 unmask raises irq", {31'b0, irq}, 32'h1);
    rd(8'h10, v); chk("R7 channel status", v, 32'h1);
    rd(8'hA0, v); chk("R7 global status", v, 32'h1);
    // R8 global EOI while stopped
    wr(8'h08, 32'h2);
    rd(8'hA4, v);
    chk("R8 global eoi clears", {31'b0, irq}, 32'h0);
    rd(8'hA8, v); chk("R8 global raw cleared", v, 32'h0);

    // R8 expiry coinciding with EOI keeps flag
    wr(8'h00, 32'd0); wr(8'h08, 32'h3);
    idle(2);
    rd(8'h0C, v);
    chk("R8 expire wins", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0); rd(8'h0C, v);
    chk("R8 cleared after stop", {31'b0, irq}, 32'h0);
    chk("R9 pready", {31'b0, pready}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule